// File: doc/BRIEF.md
# Cross-Clock Bypass Mailbox

This block carries a single word from a sending port (port A, clocked by `clk_a`) to the output register of a receiving port (port B, clocked by `clk_b`). The word does not pass through the FIFO storage. The two clocks are unrelated. A mode bit owned by port A selects between two modes:

- **FIFO mode.** The block is transparent. Port A writes are steered to the FIFO write strobe. Port B reads are steered to the FIFO read strobe, and the FIFO head word is loaded into the port B output register. Both ports see the FIFO's own full and empty flags.
- **Bypass mode.** The block overrides those flags and runs a one-word mailbox.

In bypass mode, the sender's active-low full flag means "a word is still waiting". The receiver's empty flag goes high when a word can be taken. An active-low mode indicator in the `clk_b` domain tells port B that bypass is active.

The handshake uses a request toggle in the `clk_a` domain and an acknowledge toggle in the `clk_b` domain. Each toggle reaches the other domain through a two-flop synchronizer. The held word is not synchronized. Its register cannot change while a word is pending, so it is stable whenever port B samples it.

The sender controller has three states:

- `SND_FIFO` moves to `SND_IDLE` on a mode write of 1.
- `SND_IDLE` moves to `SND_WAIT` on a data write, which captures the word and flips the request toggle.
- `SND_IDLE` moves to `SND_FIFO` on a mode write of 0.
- `SND_WAIT` moves to `SND_IDLE` once the synchronized acknowledge equals the request.

The receiver controller has three states:

- `RCV_FIFO` moves to `RCV_EMPTY` or `RCV_READY` when the synchronized mode turns on.
- `RCV_EMPTY` moves to `RCV_READY` when the synchronized request differs from the acknowledge.
- `RCV_EMPTY` moves to `RCV_FIFO` when the synchronized mode turns off.
- `RCV_READY` moves to `RCV_EMPTY` on a read, which loads the output register and flips the acknowledge toggle.

Top module: `bypass_mailbox`

## Requirements
- R1: After reset the block is in FIFO mode. `b_byp_n` is 1, `b_dout` is 0, `a_ff_n` equals `a_fifo_ff_n` and `b_ef_n` equals `b_fifo_ef_n`.
- R2: In FIFO mode, `a_ff_n` mirrors `a_fifo_ff_n` and `b_ef_n` mirrors `b_fifo_ef_n`. A port A write (`a_en_n`=0, `a_rnw`=0) raises `a_fifo_we` only while `a_fifo_ff_n` is 1. A port B read (`b_en_n`=0, `b_rnw`=1) with `b_fifo_ef_n`=1 raises `b_fifo_re` and loads `b_fifo_rdata` into `b_dout` at that `clk_b` edge.
- R3: A `clk_a` edge with `a_mode_we`=1 sets the mode to `a_mode_val`, but only when no word is pending. A change requested while a word is pending is dropped. In bypass with no word pending, a write and a mode clear on the same edge resolve to the write, and the mode stays on.
- R4: `b_byp_n` is 0 exactly while the mode seen through the synchronizer is bypass. It follows a mode change after the third rising `clk_b` edge that comes after the `clk_a` edge that changed the mode.
- R5: In bypass with no word pending, a port A write captures `a_data`, drives `a_ff_n` to 0 from that edge on, and does not raise `a_fifo_we`. In bypass, `a_ff_n` ignores `a_fifo_ff_n`.
- R6: A port A write made while a word is pending is dropped. `a_ff_n` stays 0, and the word later delivered to `b_dout` is the one first captured.
- R7: In bypass, `b_ef_n` rises after the third rising `clk_b` edge that follows the capturing `clk_a` edge. It ignores `b_fifo_ef_n`.
- R8: A port B read while `b_ef_n` is 1 in bypass loads the held word into `b_dout`. `b_ef_n` falls after that edge. `b_fifo_re` stays 0 throughout bypass.
- R9: After the consuming read, `a_ff_n` returns to 1 after the third rising `clk_a` edge that follows that read edge. A new word can then be written.
- R10: A port B read in bypass while `b_ef_n` is 0 leaves `b_dout` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Sender (port A) clock |
| clk_b | input | 1 | Receiver (port B) clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_en_n | input | 1 | Port A transfer enable, active low |
| a_rnw | input | 1 | Port A direction, 0 = write |
| a_data | input | DATA_W | Port A write data |
| a_mode_we | input | 1 | Mode bit write strobe |
| a_mode_val | input | 1 | New mode value, 1 = bypass |
| a_fifo_ff_n | input | 1 | Full flag of the A-to-B FIFO storage, active low |
| a_ff_n | output | 1 | Sender full flag as seen by port A |
| a_fifo_we | output | 1 | Write strobe to the FIFO storage |
| b_en_n | input | 1 | Port B transfer enable, active low |
| b_rnw | input | 1 | Port B direction, 1 = read |
| b_fifo_ef_n | input | 1 | Empty flag of the FIFO storage, active low |
| b_fifo_rdata | input | DATA_W | Head word of the FIFO storage |
| b_ef_n | output | 1 | Receiver empty flag as seen by port B |
| b_byp_n | output | 1 | Bypass-active indicator, active low, `clk_b` domain |
| b_fifo_re | output | 1 | Read strobe to the FIFO storage |
| b_dout | output | DATA_W | Port B output register |

## Verification
The bench targets writes that arrive while a word is still pending. A design that accepted them would overwrite the held word, and port B would receive the wrong value. It also tries a mode clear while a word is pending, and a write together with a mode clear in the same cycle. A design that honoured the clear would strand a word or switch mode under a live handshake. Reads against an empty mailbox are checked for corrupting `b_dout`. The flags are compared on every edge of both clocks against a latency-aware model, so a missing or extra synchronizer stage, or a flag that still tracks the FIFO inputs in bypass, shows up as a one-cycle mismatch.

// File: rtl/bypmb_pkg.sv
`timescale 1ns/1ps
package bypmb_pkg;
    typedef enum logic [1:0] {
        SND_FIFO = 2'd0,
        SND_IDLE = 2'd1,
        SND_WAIT = 2'd2
    } snd_state_e;

    typedef enum logic [1:0] {
        RCV_FIFO  = 2'd0,
        RCV_EMPTY = 2'd1,
        RCV_READY = 2'd2
    } rcv_state_e;
endpackage

// File: rtl/bypmb_sync.sv
`timescale 1ns/1ps
module bypmb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= '0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bypmb_send_ctl.sv
`timescale 1ns/1ps
module bypmb_send_ctl
    import bypmb_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              mode_we,
    input  logic              mode_val,
    input  logic              ack_seen,
    input  logic              fifo_ff_n,
    output logic              ff_n,
    output logic              fifo_we,
    output logic              mode_q,
    output logic              req_q,
    output logic [DATA_W-1:0] hold_q
);
    snd_state_e st_q, st_d;
    logic       take;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SND_FIFO;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        take = 1'b0;
        unique case (st_q)
            SND_FIFO: begin
                if (mode_we && mode_val) st_d = SND_IDLE;
            end
            SND_IDLE: begin
                if (wr_stb) begin
                    st_d = SND_WAIT;
                    take = 1'b1;
                end else if (mode_we && !mode_val) begin
                    st_d = SND_FIFO;
                end
            end
            SND_WAIT: begin
                if (ack_seen == req_q) st_d = SND_IDLE;
            end
            default: st_d = SND_FIFO;
        endcase
    end

    // mode bit, held word and request toggle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            req_q  <= 1'b0;
            hold_q <= '0;
        end else begin
            mode_q <= (st_d != SND_FIFO);
            if (take) begin
                hold_q <= wr_data;
                req_q  <= ~req_q;
            end
        end
    end

    // outputs
    always_comb begin
        ff_n    = 1'b1;
        fifo_we = 1'b0;
        unique case (st_q)
            SND_FIFO: begin
                ff_n    = fifo_ff_n;
                fifo_we = wr_stb && fifo_ff_n;
            end
            SND_IDLE: ff_n = 1'b1;
            SND_WAIT: ff_n = 1'b0;
            default:  ff_n = 1'b1;
        endcase
    end

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SND_WAIT) |=> $stable(hold_q));

    // R3
    mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SND_WAIT) |=> $stable(mode_q));

    // R5
    wr_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SND_IDLE && wr_stb) |=> (!ff_n && req_q != $past(req_q)));

    // R9
    req_only_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q != $past(req_q)) |-> ($past(st_q) == SND_IDLE && $past(wr_stb)));
endmodule

// File: rtl/bypmb_recv_ctl.sv
`timescale 1ns/1ps
module bypmb_recv_ctl
    import bypmb_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              mode_seen,
    input  logic              req_seen,
    input  logic [DATA_W-1:0] hold_i,
    input  logic              fifo_ef_n,
    input  logic [DATA_W-1:0] fifo_rdata,
    output logic              ef_n,
    output logic              byp_n,
    output logic              fifo_re,
    output logic              ack_q,
    output logic [DATA_W-1:0] dout
);
    rcv_state_e st_q, st_d;
    logic       give;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RCV_FIFO;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        give = 1'b0;
        unique case (st_q)
            RCV_FIFO: begin
                if (mode_seen) st_d = (req_seen != ack_q) ? RCV_READY : RCV_EMPTY;
            end
            RCV_EMPTY: begin
                if (!mode_seen)             st_d = RCV_FIFO;
                else if (req_seen != ack_q) st_d = RCV_READY;
            end
            RCV_READY: begin
                if (rd_stb) begin
                    st_d = RCV_EMPTY;
                    give = 1'b1;
                end
            end
            default: st_d = RCV_FIFO;
        endcase
    end

    // outputs (combinational part)
    always_comb begin
        ef_n    = 1'b0;
        byp_n   = 1'b0;
        fifo_re = 1'b0;
        unique case (st_q)
            RCV_FIFO: begin
                ef_n    = fifo_ef_n;
                byp_n   = 1'b1;
                fifo_re = rd_stb && fifo_ef_n;
            end
            RCV_EMPTY: ef_n = 1'b0;
            RCV_READY: ef_n = 1'b1;
            default:   ef_n = 1'b0;
        endcase
    end

    // output register and acknowledge toggle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= '0;
            ack_q <= 1'b0;
        end else if (give) begin
            dout  <= hold_i;
            ack_q <= ~ack_q;
        end else if (fifo_re) begin
            dout  <= fifo_rdata;
        end
    end

    // R8
    byp_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RCV_READY && rd_stb) |=> (dout == $past(hold_i) && !ef_n));

    // R10
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RCV_EMPTY) |=> $stable(dout));

    // R8
    no_fifo_in_byp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_re |-> byp_n);

    // R7
    ack_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q != $past(ack_q)) |-> ($past(st_q) == RCV_READY && $past(rd_stb)));
endmodule

// File: rtl/bypass_mailbox.sv
`timescale 1ns/1ps
module bypass_mailbox #(
    parameter int DATA_W      = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic              a_en_n,
    input  logic              a_rnw,
    input  logic [DATA_W-1:0] a_data,
    input  logic              a_mode_we,
    input  logic              a_mode_val,
    input  logic              a_fifo_ff_n,
    output logic              a_ff_n,
    output logic              a_fifo_we,
    input  logic              b_en_n,
    input  logic              b_rnw,
    input  logic              b_fifo_ef_n,
    input  logic [DATA_W-1:0] b_fifo_rdata,
    output logic              b_ef_n,
    output logic              b_byp_n,
    output logic              b_fifo_re,
    output logic [DATA_W-1:0] b_dout
);
    localparam int B_XING_W = 2;

    logic              a_wr;
    logic              b_rd;
    logic              mode_a;
    logic              req_a;
    logic              ack_b;
    logic              ack_in_a;
    logic [DATA_W-1:0] hold_a;
    logic [B_XING_W-1:0] to_b_sync;

    assign a_wr = !a_en_n && !a_rnw;
    assign b_rd = !b_en_n && b_rnw;

    bypmb_send_ctl #(.DATA_W(DATA_W)) u_send (
        .clk       (clk_a),
        .rst_n     (rst_n),
        .wr_stb    (a_wr),
        .wr_data   (a_data),
        .mode_we   (a_mode_we),
        .mode_val  (a_mode_val),
        .ack_seen  (ack_in_a),
        .fifo_ff_n (a_fifo_ff_n),
        .ff_n      (a_ff_n),
        .fifo_we   (a_fifo_we),
        .mode_q    (mode_a),
        .req_q     (req_a),
        .hold_q    (hold_a)
    );

    bypmb_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk_a),
        .rst_n (rst_n),
        .d     (ack_b),
        .q     (ack_in_a)
    );

    bypmb_sync #(.W(B_XING_W), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (clk_b),
        .rst_n (rst_n),
        .d     ({mode_a, req_a}),
        .q     (to_b_sync)
    );

    bypmb_recv_ctl #(.DATA_W(DATA_W)) u_recv (
        .clk        (clk_b),
        .rst_n      (rst_n),
        .rd_stb     (b_rd),
        .mode_seen  (to_b_sync[1]),
        .req_seen   (to_b_sync[0]),
        .hold_i     (hold_a),
        .fifo_ef_n  (b_fifo_ef_n),
        .fifo_rdata (b_fifo_rdata),
        .ef_n       (b_ef_n),
        .byp_n      (b_byp_n),
        .fifo_re    (b_fifo_re),
        .ack_q      (ack_b),
        .dout       (b_dout)
    );
endmodule

// File: tb/bypass_mailbox_tb.sv
`timescale 1ns/1ps
module bypass_mailbox_tb;
    localparam int DW = 18;

    logic          clk_a, clk_b, rst_n;
    logic          a_en_n, a_rnw, a_mode_we, a_mode_val, a_fifo_ff_n;
    logic [DW-1:0] a_data;
    logic          a_ff_n, a_fifo_we;
    logic          b_en_n, b_rnw, b_fifo_ef_n;
    logic [DW-1:0] b_fifo_rdata;
    logic          b_ef_n, b_byp_n, b_fifo_re;
    logic [DW-1:0] b_dout;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    bit  ended  = 0;
    bit  in_r1  = 1;

    // reference model state
    bit            m_abyp, m_apend, m_req, m_ack, m_dropped;
    bit            m_bbyp, m_brdy;
    logic [DW-1:0] m_hold, m_dout;
    bit            aq [2];
    bit            rq [2];
    bit            mq [2];
    string         m_dtag = "R1";

    bypass_mailbox #(.DATA_W(DW), .SYNC_STAGES(2)) u_dut (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .a_en_n(a_en_n), .a_rnw(a_rnw), .a_data(a_data),
        .a_mode_we(a_mode_we), .a_mode_val(a_mode_val), .a_fifo_ff_n(a_fifo_ff_n),
        .a_ff_n(a_ff_n), .a_fifo_we(a_fifo_we),
        .b_en_n(b_en_n), .b_rnw(b_rnw), .b_fifo_ef_n(b_fifo_ef_n),
        .b_fifo_rdata(b_fifo_rdata), .b_ef_n(b_ef_n), .b_byp_n(b_byp_n),
        .b_fifo_re(b_fifo_re), .b_dout(b_dout)
    );

    initial begin
        clk_a = 0;
        forever #5 clk_a = ~clk_a;
    end

    initial begin
        clk_b = 0;
        #1.8;
        forever #6.5 clk_b = ~clk_b;
    end

    task automatic chk(input string tag, input string sig, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, sig, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // sender-side model
    always @(posedge clk_a) begin
        bit wr;
        bit seen;
        if (!rst_n) begin
            m_abyp = 0; m_apend = 0; m_req = 0; m_hold = '0; m_dropped = 0;
            aq[0] = 0; aq[1] = 0;
        end else begin
            wr   = !a_en_n && !a_rnw;
            seen = aq[0];
            if (!m_abyp) begin
                if (a_mode_we && a_mode_val) m_abyp = 1;
            end else if (!m_apend) begin
                if (wr) begin
                    m_hold = a_data; m_req = ~m_req; m_apend = 1; m_dropped = 0;
                end else if (a_mode_we && !a_mode_val) begin
                    m_abyp = 0;
                end
            end else begin
                if (wr) m_dropped = 1;
                if (seen == m_req) m_apend = 0;
            end
            aq[0] = aq[1];
            aq[1] = m_ack;
        end
    end

    // receiver-side model
    always @(posedge clk_b) begin
        bit rd;
        bit sreq;
        bit smode;
        if (!rst_n) begin
            m_bbyp = 0; m_brdy = 0; m_ack = 0; m_dout = '0;
            rq[0] = 0; rq[1] = 0; mq[0] = 0; mq[1] = 0;
        end else begin
            rd    = !b_en_n && b_rnw;
            sreq  = rq[0];
            smode = mq[0];
            if (!m_bbyp) begin
                if (rd && b_fifo_ef_n) begin
                    m_dout = b_fifo_rdata; m_dtag = "R2";
                end
                if (smode) begin
                    m_bbyp = 1; m_brdy = (sreq != m_ack);
                end
            end else if (!m_brdy) begin
                if (rd) m_dtag = "R10";
                if (!smode)              m_bbyp = 0;
                else if (sreq != m_ack)  m_brdy = 1;
            end else if (rd) begin
                m_dout = m_hold; m_ack = ~m_ack; m_brdy = 0;
                m_dtag = m_dropped ? "R6" : "R8";
            end
            rq[0] = rq[1]; rq[1] = m_req;
            mq[0] = mq[1]; mq[1] = m_abyp;
        end
    end

    // compare sender outputs every clk_a cycle
    always @(negedge clk_a) begin
        bit wr;
        string t;
        if (rst_n && !ended) begin
            wr = !a_en_n && !a_rnw;
            t  = in_r1 ? "R1" : (m_abyp ? (m_apend ? (m_dropped ? "R6" : "R5") : "R9") : "R2");
            chk(t, "a_ff_n", 32'(a_ff_n), 32'(m_abyp ? !m_apend : a_fifo_ff_n));
            chk(in_r1 ? "R1" : (m_abyp ? "R5" : "R2"), "a_fifo_we", 32'(a_fifo_we),
                32'(!m_abyp && wr && a_fifo_ff_n));
        end
    end

    // compare receiver outputs every clk_b cycle
    always @(negedge clk_b) begin
        bit rd;
        if (rst_n && !ended) begin
            rd = !b_en_n && b_rnw;
            chk(in_r1 ? "R1" : (m_bbyp ? "R7" : "R2"), "b_ef_n", 32'(b_ef_n),
                32'(m_bbyp ? m_brdy : b_fifo_ef_n));
            chk(in_r1 ? "R1" : "R4", "b_byp_n", 32'(b_byp_n), 32'(!m_bbyp));
            chk(in_r1 ? "R1" : m_dtag, "b_dout", 32'(b_dout), 32'(m_dout));
            chk(m_bbyp ? "R8" : "R2", "b_fifo_re", 32'(b_fifo_re),
                32'(!m_bbyp && rd && b_fifo_ef_n));
        end
    end

    task automatic a_step(input bit en_n, input bit rnw, input logic [DW-1:0] d,
                          input bit mwe, input bit mval);
        a_en_n      = en_n;
        a_rnw       = rnw;
        a_data      = d;
        a_mode_we   = mwe;
        a_mode_val  = mval;
        a_fifo_ff_n = 1'($urandom % 2);
        @(posedge clk_a);
        #2;
    endtask

    task automatic a_idle(input int n);
        for (int i = 0; i < n; i++) a_step(1, 1, '0, 0, 0);
    endtask

    task automatic a_wait_free();
        for (int i = 0; i < 200; i++) begin
            if (a_ff_n) break;
            a_step(1, 1, '0, 0, 0);
        end
    endtask

    // port A stimulus
    initial begin
        a_en_n = 1; a_rnw = 1; a_data = '0; a_mode_we = 0; a_mode_val = 0; a_fifo_ff_n = 1;
        rst_n = 0;
        #33 rst_n = 1;
        @(posedge clk_a); #2;
        a_idle(4);
        in_r1 = 0;
        // R2: FIFO mode traffic
        for (int i = 0; i < 20; i++) a_step(1'($urandom % 2), 1'($urandom % 3 == 0), DW'($urandom), 0, 0);
        // R3: enter bypass
        a_step(1, 1, '0, 1, 1);
        a_idle(6);
        // R5: first word, then R6 writes while pending, and R3 clear while pending
        a_step(0, 0, 18'h2A5A5, 0, 0);
        a_step(0, 0, 18'h11111, 0, 0);
        a_step(1, 1, '0, 1, 0);
        a_step(0, 0, 18'h22222, 0, 0);
        if (!a_ff_n) chk("R6", "a_ff_n", 32'(a_ff_n), 32'd0);
        a_idle(6);
        chk("R3", "b_byp_n", 32'(b_byp_n), 32'd0);
        a_wait_free();
        // R9: stream words
        for (int w = 0; w < 30; w++) begin
            a_wait_free();
            a_step(0, 0, DW'($urandom), 0, 0);
            if ($urandom % 2 == 1) a_step(0, 0, DW'($urandom), 0, 0);
        end
        a_wait_free();
        // R3: write and clear on one edge, write wins
        a_step(0, 0, 18'h3C3C3, 1, 0);
        chk("R3", "a_ff_n", 32'(a_ff_n), 32'd0);
        a_wait_free();
        a_idle(8);
        chk("R3", "b_byp_n", 32'(b_byp_n), 32'd0);
        // leave bypass
        a_step(1, 1, '0, 1, 0);
        a_idle(8);
        chk("R4", "b_byp_n", 32'(b_byp_n), 32'd1);
        for (int i = 0; i < 20; i++) a_step(1'($urandom % 2), 1'($urandom % 3 == 0), DW'($urandom), 0, 0);
        done = 1;
        #40;
        finish_up();
    end

    // port B stimulus
    initial begin
        b_en_n = 1; b_rnw = 1; b_fifo_ef_n = 0; b_fifo_rdata = '0;
        @(posedge rst_n);
        while (!done) begin
            @(posedge clk_b);
            #2;
            b_en_n       = ($urandom % 4 == 0);
            b_rnw        = ($urandom % 8 != 0);
            b_fifo_ef_n  = 1'($urandom % 2);
            b_fifo_rdata = DW'($urandom);
        end
    end

    // watchdog
    initial begin
        #1000000;
        if (!ended) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_up();
        end
    end
endmodule